// File: doc/BRIEF.md
# Secondary Core Release Table

This block is a small memory-mapped table with one 32-byte slot per processor core. Boot software writes launch parameters into a slot and then clears a hold flag to start the matching secondary core. The table sits behind a simple slave port. That port accepts 1-, 2- and 4-byte reads and writes. Multi-byte values are big-endian, and data is right-justified on the data buses.

Each slot holds four fields. The start address is 64 bits at slot bytes 0 to 7, and its bit 0 at byte 7 is the hold flag. The boot argument is 64 bits at bytes 8 to 15. The core identifier is 32 bits at bytes 20 to 23. The remaining bytes are spare storage. The entry index is the address divided by 32, and the byte offset is the address modulo 32.

A write can leave a slot's start address with bit 0 clear. When that happens, the block does three things on the next clock edge:
- It raises a one-cycle release pulse for that core.
- It presents the launch values: the offset inside a fixed 64 MiB window, the window base, the window size and the boot argument.
- It stamps the slot's identifier field with the core's hardware identifier.

Slot 0 belongs to the primary core and is never writable. Slots at or above the number of cores actually fitted are not writable either.

Top module: `core_rel_table`

## Requirements
- R1: After reset, slot i reads back start address 1 (held), boot argument i and identifier i, and every other byte reads 0. No release pulse is active and no read response is pending.
- R2: A read request with size code 0, 1 or 2 (1, 2 or 4 bytes) sets rd_valid on the following clock edge. rdata then holds the addressed bytes in big-endian order, right-justified, with the upper bits zero.
- R3: A read with size code 3 sets rd_valid and rd_err on the following edge, and rdata reads zero.
- R4: An accepted write of 1, 2 or 4 bytes changes only the addressed bytes. The last byte of the access takes wdata[7:0].
- R5: Writes to slot 0 leave the table unchanged and never produce a release.
- R6: Writes to slots at or above NUM_CORES leave the table unchanged and never produce a release.
- R7: After any accepted write, the block raises rel_pulse[slot] for exactly one cycle, on the following edge, if bit 0 of that slot's start address is 0. This holds whichever field the write touched.
- R8: With a release, the launch outputs carry values taken from the start address after the write. rel_slot is the slot index. start_ofs is the start address ANDed with 2^WIN_BITS-1. win_base is the start address with its low WIN_BITS bits cleared. win_size is 2^WIN_BITS. boot_arg is the slot's boot argument.
- R9: A release overwrites the slot's identifier field (bytes 20 to 23) with core_id_base plus the slot index. This overrides any bytes the same write put there.
- R10: A write with size code 3 changes nothing and never produces a release.
- R11: An accepted write that leaves bit 0 of the start address set produces no release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address (slot index, byte offset) |
| size | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = unsupported |
| wdata | input | 32 | Right-justified write data |
| core_id_base | input | 32 | Hardware identifier of core 0; core i is this plus i |
| rd_valid | output | 1 | Read response valid |
| rd_err | output | 1 | Read had an unsupported size |
| rdata | output | 32 | Right-justified read data |
| rel_pulse | output | NUM_SLOTS | One-cycle release, one bit per core |
| rel_slot | output | SLOT_W | Slot of the latest release |
| start_ofs | output | 64 | Start offset inside the window |
| win_base | output | 64 | Window base address |
| win_size | output | 64 | Window size in bytes |
| boot_arg | output | 64 | First argument for the released core |

## Verification
The bench builds the table with all 32 slots and with NUM_CORES set to 6. This leaves most of the address space in slots that exist but cannot be written, so random writes regularly test the R6 discard path next to the slot 0 path. The window width keeps its 26-bit default. Directed writes load start addresses whose upper bits are non-zero, so the split between offset and base is visible. The core identifier base is set to 0x100, which makes the stamped identifier distinct from the reset value.

// File: rtl/core_rel_pkg.sv
// Shared constants, types and helpers for the core release table.
// Assumes a fixed 32-byte slot in which byte 0 maps to the most significant
// bits of the packed vector, so big-endian fields are plain part-selects.
package core_rel_pkg;

    localparam int ENTRY_BYTES = 32;
    localparam int ENTRY_W     = ENTRY_BYTES * 8;
    localparam int OFS_W       = $clog2(ENTRY_BYTES);

    // most significant bit of each field inside the packed slot
    localparam int START_HI = ENTRY_W - 1;        // bytes 0..7
    localparam int ARG_HI   = ENTRY_W - 8 * 8 - 1; // bytes 8..15
    localparam int ID_HI    = ENTRY_W - 20 * 8 - 1; // bytes 20..23
    localparam int START_LSB = ENTRY_W - 64;       // hold flag position

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // number of bytes moved by an access; 0 for the unsupported code
    function automatic int access_bytes(input logic [1:0] code);
        case (acc_size_e'(code))
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

    // contents of slot idx right after reset
    function automatic entry_t reset_entry(input int idx);
        entry_t e;
        e = '0;
        e[START_HI -: 64] = 64'd1;
        e[ARG_HI -: 64]   = 64'(idx);
        e[ID_HI -: 32]    = 32'(idx);
        return e;
    endfunction

endpackage

// File: rtl/core_rel_wmerge.sv
// Merges a 1-, 2- or 4-byte right-justified write into a copy of one slot.
// Assumes byte k of the access lands at offset (ofs + k) modulo the slot size;
// an unsupported size code leaves the slot untouched.
module core_rel_wmerge
    import core_rel_pkg::*;
(
    input  entry_t           cur,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    input  logic [31:0]      wdata,
    output entry_t           merged
);

    int               nbytes;
    logic [OFS_W-1:0] pos;

    // overlay the written bytes, most significant data byte first
    always_comb begin
        merged = cur;
        nbytes = access_bytes(size);
        pos    = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nbytes) begin
                pos = ofs + OFS_W'(k);
                merged[8 * (ENTRY_BYTES - 1 - int'(pos)) +: 8] =
                    wdata[8 * (nbytes - 1 - k) +: 8];
            end
        end
    end

endmodule

// File: rtl/core_rel_launch.sv
// Derives the launch values of one slot and its identifier-stamped image.
// Assumes the window is a power of two of 2**WIN_BITS bytes.
module core_rel_launch
    import core_rel_pkg::*;
#(
    parameter int SLOT_W   = 5,
    parameter int WIN_BITS = 26
) (
    input  entry_t            ent,
    input  logic [SLOT_W-1:0] slot,
    input  logic [31:0]       id_base,
    output logic              held,
    output logic [63:0]       start_ofs,
    output logic [63:0]       win_base,
    output logic [63:0]       boot_arg,
    output entry_t            stamped
);

    localparam logic [63:0] WIN_MASK = (64'd1 << WIN_BITS) - 64'd1;

    logic [63:0] start;

    // split the start address and pick up the argument
    always_comb begin
        start     = ent[START_HI -: 64];
        held      = start[0];
        start_ofs = start & WIN_MASK;
        win_base  = start & ~WIN_MASK;
        boot_arg  = ent[ARG_HI -: 64];
    end

    // slot image with the real core identifier written in
    always_comb begin
        stamped = ent;
        stamped[ID_HI -: 32] = id_base + 32'(slot);
    end

endmodule

// File: rtl/core_rel_rdport.sv
// Extracts a right-justified big-endian value of 1, 2 or 4 bytes from a slot.
// Flags the unsupported size code and returns zero for it.
module core_rel_rdport
    import core_rel_pkg::*;
(
    input  entry_t           ent,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output logic [31:0]      data,
    output logic             bad
);

    int               nbytes;
    logic [OFS_W-1:0] pos;

    // gather the addressed bytes, first byte most significant
    always_comb begin
        nbytes = access_bytes(size);
        bad    = (nbytes == 0);
        data   = '0;
        pos    = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nbytes) begin
                pos  = ofs + OFS_W'(k);
                data = {data[23:0], ent[8 * (ENTRY_BYTES - 1 - int'(pos)) +: 8]};
            end
        end
    end

endmodule

// File: rtl/core_rel_table.sv
// Core release table: one 32-byte slot per core, written over a simple slave
// port. The block releases a core when an accepted write leaves that core's
// hold flag clear. Assumes one access per cycle, accesses that do not cross a
// slot, and NUM_SLOTS a power of two. Read results and release outputs are
// registered and appear one edge after the request.
module core_rel_table
    import core_rel_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_CORES = 4,
    parameter int WIN_BITS  = 26,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           size,
    input  logic [31:0]          wdata,
    input  logic [31:0]          core_id_base,
    output logic                 rd_valid,
    output logic                 rd_err,
    output logic [31:0]          rdata,
    output logic [NUM_SLOTS-1:0] rel_pulse,
    output logic [SLOT_W-1:0]    rel_slot,
    output logic [63:0]          start_ofs,
    output logic [63:0]          win_base,
    output logic [63:0]          win_size,
    output logic [63:0]          boot_arg
);

    entry_t           tbl [NUM_SLOTS];
    logic [SLOT_W-1:0] slot;
    logic [OFS_W-1:0] ofs;
    entry_t           cur;
    entry_t           merged;
    entry_t           stamped;
    logic             held;
    logic [63:0]      nxt_ofs;
    logic [63:0]      nxt_base;
    logic [63:0]      nxt_arg;
    logic [31:0]      rd_data;
    logic             rd_bad;
    logic             wr_ok;
    logic             fire;
    logic             rd_req;

    // decode the address into slot and byte offset
    always_comb begin
        slot = addr[ADDR_W-1:OFS_W];
        ofs  = addr[OFS_W-1:0];
        cur  = tbl[slot];
    end

    core_rel_wmerge u_wmerge (
        .cur    (cur),
        .ofs    (ofs),
        .size   (size),
        .wdata  (wdata),
        .merged (merged)
    );

    core_rel_launch #(
        .SLOT_W   (SLOT_W),
        .WIN_BITS (WIN_BITS)
    ) u_launch (
        .ent       (merged),
        .slot      (slot),
        .id_base   (core_id_base),
        .held      (held),
        .start_ofs (nxt_ofs),
        .win_base  (nxt_base),
        .boot_arg  (nxt_arg),
        .stamped   (stamped)
    );

    core_rel_rdport u_rdport (
        .ent  (cur),
        .ofs  (ofs),
        .size (size),
        .data (rd_data),
        .bad  (rd_bad)
    );

    // accept rule: well-sized write to a fitted secondary slot
    always_comb begin
        rd_req = req && !we;
        wr_ok  = req && we && (size != SZ_BAD) && (slot != '0)
                 && (int'(slot) < NUM_CORES);
        fire   = wr_ok && !held;
    end

    // slot storage with reset image and identifier stamping on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                tbl[i] <= reset_entry(i);
            end
        end else if (wr_ok) begin
            tbl[slot] <= fire ? stamped : merged;
        end
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_err   <= rd_req && rd_bad;
            if (rd_req) begin
                rdata <= rd_data;
            end
        end
    end

    // registered release pulse and launch values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_pulse <= '0;
            rel_slot  <= '0;
            start_ofs <= '0;
            win_base  <= '0;
            boot_arg  <= '0;
        end else begin
            rel_pulse <= fire ? (NUM_SLOTS'(1) << slot) : '0;
            if (fire) begin
                rel_slot  <= slot;
                start_ofs <= nxt_ofs;
                win_base  <= nxt_base;
                boot_arg  <= nxt_arg;
            end
        end
    end

    assign win_size = 64'd1 << WIN_BITS;

endmodule

// File: rtl/core_rel_table_chk.sv
// Property checker for the core release table, attached by bind below.
// Relates the registered responses to the request seen one edge earlier.
module core_rel_table_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_CORES = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req,
    input logic                 we,
    input logic [1:0]           size,
    input logic                 rd_valid,
    input logic                 rd_err,
    input logic [NUM_SLOTS-1:0] rel_pulse,
    input logic [SLOT_W-1:0]    rel_slot
);

    // R7
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));

    // R10
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> $past(req && we && size != 2'd3));

    // R5 R6
    pulse_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> (rel_slot != '0 && int'(rel_slot) < NUM_CORES
                          && rel_pulse[rel_slot]));

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req && !we));

    // R3
    rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && $past(size == 2'd3)));

endmodule

bind core_rel_table core_rel_table_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_CORES (NUM_CORES)
) u_chk (.*);

// File: tb/test_core_rel_table.sv
// Self-checking bench: directed corner cases followed by seeded random
// accesses, all compared against a byte-level model kept in the bench.
module test_core_rel_table;

    localparam int NS  = 32;
    localparam int NC  = 6;
    localparam int WB  = 26;
    localparam int SW  = $clog2(NS);
    localparam int AW  = SW + 5;
    localparam logic [31:0] IDB = 32'h100;
    localparam logic [63:0] WMASK = (64'd1 << WB) - 64'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    size = '0;
    logic [31:0]   wdata = '0;
    logic          rd_valid, rd_err;
    logic [31:0]   rdata;
    logic [NS-1:0] rel_pulse;
    logic [SW-1:0] rel_slot;
    logic [63:0]   start_ofs, win_base, win_size, boot_arg;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    logic [7:0] mdl [NS][32];

    core_rel_table #(.NUM_SLOTS(NS), .NUM_CORES(NC), .WIN_BITS(WB)) i_core_rel_table (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .core_id_base(IDB), .rd_valid(rd_valid), .rd_err(rd_err),
        .rdata(rdata), .rel_pulse(rel_pulse), .rel_slot(rel_slot),
        .start_ofs(start_ofs), .win_base(win_base), .win_size(win_size),
        .boot_arg(boot_arg)
    );

    always #4 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: act %0d cycles exp < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    function automatic int nb(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    endfunction

    function automatic logic [63:0] field64(input int s, input int b);
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++) v = {v[55:0], mdl[s][b + k]};
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            for (int j = 0; j < 32; j++) mdl[i][j] = 8'h00;
            mdl[i][7]  = 8'h01;
            mdl[i][14] = 8'(i >> 8);
            mdl[i][15] = 8'(i);
            mdl[i][22] = 8'(i >> 8);
            mdl[i][23] = 8'(i);
        end
    endtask

    // one access, expectations from the model, checks one edge later
    task automatic op(input bit w, input int s, input int o, input int sz,
                      input logic [31:0] d, input string tag);
        int n = nb(sz);
        bit acc, fire;
        logic [31:0] exp_rd = '0;
        logic [31:0] idv;
        @(negedge clk);
        req = 1'b1; we = w; addr = AW'(s * 32 + o); size = 2'(sz); wdata = d;
        acc = 1'b0; fire = 1'b0;
        if (w) begin
            acc = (n != 0) && (s != 0) && (s < NC);
            if (acc) begin
                for (int k = 0; k < n; k++) mdl[s][(o + k) % 32] = 8'(d >> (8 * (n - 1 - k)));
                fire = (mdl[s][7][0] == 1'b0);
            end
        end else begin
            for (int k = 0; k < n; k++) exp_rd = {exp_rd[23:0], mdl[s][(o + k) % 32]};
        end
        @(negedge clk);
        req = 1'b0;
        if (w) begin
            chk(tag, 64'(rel_pulse), fire ? 64'(NS'(1) << s) : 64'd0);
            if (fire) begin
                chk("R8 slot", 64'(rel_slot), 64'(s));
                chk("R8 ofs", start_ofs, field64(s, 0) & WMASK);
                chk("R8 base", win_base, field64(s, 0) & ~WMASK);
                chk("R8 size", win_size, 64'd1 << WB);
                chk("R8 arg", boot_arg, field64(s, 8));
                idv = IDB + 32'(s);
                for (int k = 0; k < 4; k++) mdl[s][20 + k] = idv[8 * (3 - k) +: 8];
            end
        end else begin
            chk({tag, " valid"}, 64'(rd_valid), 64'd1);
            chk({tag, " err"}, 64'(rd_err), (n == 0) ? 64'd1 : 64'd0);
            if (n == 0) chk("R3 data", 64'(rdata), 64'd0);
            else chk(tag, 64'(rdata), 64'(exp_rd));
        end
    endtask

    initial begin
        void'($urandom(32'd20240));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulse", 64'(rel_pulse), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        // R1 reset image
        op(0, 0, 20, 2, 0, "R1 id0");
        op(0, 3, 20, 2, 0, "R1 id3");
        op(0, 31, 20, 2, 0, "R1 id31");
        op(0, 5, 4, 2, 0, "R1 start");
        op(0, 9, 12, 2, 0, "R1 arg");
        op(0, 9, 24, 2, 0, "R1 spare");
        // R3 bad read size
        op(0, 2, 4, 3, 0, "R3 read");
        // R5 primary slot
        op(1, 0, 4, 2, 32'h0, "R5 write");
        op(0, 0, 4, 2, 0, "R5 readback");
        // R6 absent core
        op(1, 7, 4, 2, 32'h0, "R6 write");
        op(0, 7, 4, 2, 0, "R6 readback");
        // R11 writes keeping the hold flag set
        op(1, 2, 12, 2, 32'h0000ABCD, "R11 arg");
        op(1, 2, 0, 2, 32'h12345678, "R11 hi");
        op(1, 2, 4, 2, 32'h9ABCDEF1, "R11 lo");
        // R7 byte clear of hold flag
        op(1, 2, 7, 0, 32'h000000F0, "R7 release");
        op(0, 2, 20, 2, 0, "R9 stamped id");
        op(1, 2, 16, 2, 32'hCAFEF00D, "R7 other field");
        // R9 write to id field on release is overridden
        op(1, 2, 20, 2, 32'h55555555, "R9 override");
        op(0, 2, 20, 2, 0, "R9 readback");
        // R10 bad write size
        op(1, 3, 4, 3, 32'h0, "R10 write");
        op(0, 3, 4, 2, 0, "R10 readback");
        // R4 partial writes
        op(1, 4, 26, 1, 32'h0000BEEF, "R4 half");
        op(0, 4, 24, 2, 0, "R4 word");
        op(1, 4, 25, 0, 32'h00000077, "R4 byte");
        op(0, 4, 24, 2, 0, "R4 word2");
        op(0, 4, 25, 0, 0, "R2 byte");
        op(0, 4, 26, 1, 0, "R2 half");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int s = int'($urandom % NS);
            int sz = int'($urandom % 4);
            int n = (nb(sz) == 0) ? 1 : nb(sz);
            int o = int'($urandom % 32) & ~(n - 1);
            bit w = 1'($urandom % 2);
            op(w, s, o, sz, $urandom, w ? "R7 random write" : "R2 random read");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule